// File: doc/BRIEF.md
# Character-Cell Text Display Address Generator

This block drives a raster text display built from character cells. A free-running dot counter splits the pixel clock into groups one character wide. Three further counters track the character column across a line, the scanline inside a character cell, and the character row down the field. From the column and row it forms the video RAM address of the current cell. One character time later it presents the fetched code together with the scanline index to a glyph lookup port. One character time after that, it loads the returned dot row into a shift register that sends one dot per pixel clock.

Horizontal and vertical sync are decoded from the same counters. They travel through the same two-stage pipeline as the dots, so sync, blanking and pixels leave the block in step. Outside the visible area of COLS by ROWS cells the dot output is held low. A graphics mode sends the video RAM byte directly to the shift register and does not use the glyph lookup. Both external memories are synchronous-read ports with one cycle of latency.

Top module: `txtvid_addr_gen`

## Requirements
- R1: While rst_n is low, dot_out, hsync and vsync are 0 and vram_addr is 0.
- R2: For every visible character group (column below COLS, row below ROWS), vram_addr equals row*COLS + column for all CHAR_W cycles of that group.
- R3: In the group after a visible fetch, glyph_addr equals {code, scanline}. The code is the byte read from the fetched address and occupies the upper CODE_W bits. The scanline within the cell occupies the low LINE_W bits.
- R4: The dot row of the cell fetched in group g leaves on dot_out during group g+2, one dot per clock, most significant bit first.
- R5: dot_out is 0 for every pixel of a group whose column is COLS or above or whose row is ROWS or above.
- R6: hsync is high during the output groups of columns HS_START up to HS_START+HS_LEN-1 of every scanline, with the same two-group lag as the dots.
- R7: vsync is high during every output group of character rows VS_START up to VS_START+VS_LEN-1, with the same lag.
- R8: The column wraps after H_TOTAL groups. The scanline advances at each column wrap and wraps after CHAR_H lines, moving to the next row. After V_ROWS rows the field restarts at column 0, row 0 and address 0, so the output repeats every H_TOTAL*CHAR_W*CHAR_H*V_ROWS cycles.
- R9: With gfx_mode high, the top CHAR_W bits of the fetched video RAM byte are shifted out in place of the glyph row, and glyph_data has no effect on dot_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfx_mode | input | 1 | 1: video RAM byte drives the dots directly |
| vram_addr | output | ADDR_W | Video RAM address of the current cell |
| vram_rdata | input | CODE_W | Video RAM read data, one cycle after the address |
| glyph_addr | output | CODE_W+LINE_W | Glyph lookup index {code, scanline} |
| glyph_data | input | CHAR_W | Glyph row, one cycle after the index |
| dot_out | output | 1 | Serial dot stream, blanked outside the visible area |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
On the last pixel of every group, three things happen in the same clock edge. The shift register loads the dot row of one cell, the fetch stage captures the code of the next cell, and the counters advance, sometimes wrapping a line or the whole field. The bench keeps every one of these edges under test by running over several line ends and two complete field wraps, in text mode and in graphics mode. At every clock it predicts the address, the glyph index, the dot, hsync and vsync from its own count of cycles since reset. Any slip between the load and the capture, or a wrong wrap, shows up as a dot or sync value mismatch at the exact pixel where it occurs.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;

   // Per-group display attributes carried alongside the fetched data.
   typedef struct packed {
      logic vis;   // cell lies inside the visible area
      logic hs;    // horizontal sync window
      logic vs;    // vertical sync window
   } txtvid_flags_t;

endpackage

// File: rtl/txtvid_timing.sv
module txtvid_timing
   import txtvid_pkg::*;
#(
   parameter int COLS     = 80,
   parameter int ROWS     = 25,
   parameter int CHAR_W   = 8,
   parameter int CHAR_H   = 8,
   parameter int H_TOTAL  = 100,
   parameter int HS_START = 84,
   parameter int HS_LEN   = 12,
   parameter int V_ROWS   = 33,
   parameter int VS_START = 28,
   parameter int VS_LEN   = 1,
   parameter int ADDR_W   = $clog2(COLS*ROWS),
   parameter int LINE_W   = $clog2(CHAR_H)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   output logic                 pix_last,
   output logic [ADDR_W-1:0]    vram_addr,
   output logic [LINE_W-1:0]    line_idx,
   output txtvid_flags_t        flags
);

   localparam int PIX_W = $clog2(CHAR_W);
   localparam int COL_W = $clog2(H_TOTAL+1);
   localparam int ROW_W = $clog2(V_ROWS+1);
   localparam int SUM_W = $clog2(COLS*ROWS + H_TOTAL + 1);

   localparam logic [PIX_W-1:0]  PIX_END   = PIX_W'(CHAR_W-1);
   localparam logic [COL_W-1:0]  COL_END   = COL_W'(H_TOTAL-1);
   localparam logic [COL_W-1:0]  COL_VIS   = COL_W'(COLS);
   localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS-1);
   localparam logic [COL_W-1:0]  HS_LO     = COL_W'(HS_START);
   localparam logic [COL_W-1:0]  HS_HI     = COL_W'(HS_START+HS_LEN);
   localparam logic [LINE_W-1:0] LINE_END  = LINE_W'(CHAR_H-1);
   localparam logic [ROW_W-1:0]  ROW_END   = ROW_W'(V_ROWS-1);
   localparam logic [ROW_W-1:0]  ROW_VIS   = ROW_W'(ROWS);
   localparam logic [ROW_W-1:0]  VS_LO     = ROW_W'(VS_START);
   localparam logic [ROW_W-1:0]  VS_HI     = ROW_W'(VS_START+VS_LEN);
   localparam logic [SUM_W-1:0]  BASE_STEP = SUM_W'(COLS);

   initial begin
      assert (CHAR_W >= 2 && CHAR_H >= 2) else $error("cell must be at least 2x2");
      assert (H_TOTAL > COLS && V_ROWS > ROWS) else $error("totals must exceed visible area");
      assert (HS_START >= COLS && HS_START+HS_LEN <= H_TOTAL && HS_LEN > 0)
         else $error("hsync window outside horizontal blanking");
      assert (VS_START >= ROWS && VS_START+VS_LEN <= V_ROWS && VS_LEN > 0)
         else $error("vsync window outside vertical blanking");
   end

   logic [PIX_W-1:0]  pix;
   logic [COL_W-1:0]  col;
   logic [LINE_W-1:0] line;
   logic [ROW_W-1:0]  row;
   logic [SUM_W-1:0]  row_base;
   logic [SUM_W-1:0]  addr_sum;
   logic              col_end, line_end, row_end;

   assign pix_last = (pix == PIX_END);
   assign col_end  = (col == COL_END);
   assign line_end = (line == LINE_END);
   assign row_end  = (row == ROW_END);

   // dot counter: splits the pixel clock into character groups
   always_ff @(posedge clk) begin
      if (!rst_n)        pix <= '0;
      else if (pix_last) pix <= '0;
      else               pix <= pix + PIX_W'(1);
   end

   // column / scanline / row chain with incremental row base
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col      <= '0;
         line     <= '0;
         row      <= '0;
         row_base <= '0;
      end else if (pix_last) begin
         if (col_end) begin
            col <= '0;
            if (line_end) begin
               line <= '0;
               if (row_end) begin
                  row      <= '0;
                  row_base <= '0;
               end else begin
                  row <= row + ROW_W'(1);
                  if (row < ROW_VIS) row_base <= row_base + BASE_STEP;
               end
            end else begin
               line <= line + LINE_W'(1);
            end
         end else begin
            col <= col + COL_W'(1);
         end
      end
   end

   assign addr_sum  = row_base + SUM_W'(col);
   assign vram_addr = addr_sum[ADDR_W-1:0];
   assign line_idx  = line;

   always_comb begin
      flags.vis = (col < COL_VIS) && (row < ROW_VIS);
      flags.hs  = (col >= HS_LO) && (col < HS_HI);
      flags.vs  = (row >= VS_LO) && (row < VS_HI);
   end

   AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_last && col_end) |=> (col == '0) && (pix == '0))                 // R8
      else $error("column did not wrap at end of line");

   AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_last && col_end && line_end && row_end) |=>
         (row == '0) && (line == '0) && (vram_addr == '0))                   // R8
      else $error("field did not restart at address 0");

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_last && flags.vis && (col != COL_LAST)) |=>
         (vram_addr == $past(vram_addr) + ADDR_W'(1)))                       // R2
      else $error("address did not step by one cell");

endmodule

// File: rtl/txtvid_fetch.sv
module txtvid_fetch
   import txtvid_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int LINE_W = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       pix_last,
   input  logic [CODE_W-1:0]          vram_rdata,
   input  logic [LINE_W-1:0]          line_idx,
   input  txtvid_flags_t              flags_in,
   output logic [CODE_W-1:0]          code_q,
   output logic [CODE_W+LINE_W-1:0]   glyph_addr,
   output txtvid_flags_t              flags_out
);

   logic [LINE_W-1:0] line_q;

   // Capture the code read during this group; it indexes the glyph port
   // for the whole next group.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q    <= '0;
         line_q    <= '0;
         flags_out <= '0;
      end else if (pix_last) begin
         code_q    <= vram_rdata;
         line_q    <= line_idx;
         flags_out <= flags_in;
      end
   end

   assign glyph_addr = {code_q, line_q};

endmodule

// File: rtl/txtvid_shifter.sv
module txtvid_shifter
   import txtvid_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int CODE_W = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_last,
   input  logic               gfx_mode,
   input  logic [CHAR_W-1:0]  glyph_data,
   input  logic [CODE_W-1:0]  code_in,
   input  txtvid_flags_t      flags_in,
   output logic               dot_out,
   output logic               hsync,
   output logic               vsync
);

   logic [CHAR_W-1:0] bypass_row;
   logic [CHAR_W-1:0] load_row;
   logic [CHAR_W-1:0] shreg;
   txtvid_flags_t     flags_q;

   generate
      if (CODE_W >= CHAR_W) begin : g_byp_trim
         assign bypass_row = code_in[CODE_W-1 -: CHAR_W];
      end else begin : g_byp_pad
         assign bypass_row = {code_in, {(CHAR_W-CODE_W){1'b0}}};
      end
   endgenerate

   assign load_row = gfx_mode ? bypass_row : glyph_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg   <= '0;
         flags_q <= '0;
      end else if (pix_last) begin
         shreg   <= load_row;
         flags_q <= flags_in;
      end else begin
         shreg   <= {shreg[CHAR_W-2:0], 1'b0};
      end
   end

   assign dot_out = shreg[CHAR_W-1] & flags_q.vis;
   assign hsync   = flags_q.hs;
   assign vsync   = flags_q.vs;

   AST_HS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> !dot_out)                                                     // R5
      else $error("dot during horizontal sync");

   AST_VS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> !dot_out)                                                     // R5
      else $error("dot during vertical sync");

endmodule

// File: rtl/txtvid_addr_gen.sv
module txtvid_addr_gen
   import txtvid_pkg::*;
#(
   parameter int COLS     = 80,
   parameter int ROWS     = 25,
   parameter int CHAR_W   = 8,
   parameter int CHAR_H   = 8,
   parameter int CODE_W   = 8,
   parameter int H_TOTAL  = 100,
   parameter int HS_START = 84,
   parameter int HS_LEN   = 12,
   parameter int V_ROWS   = 33,
   parameter int VS_START = 28,
   parameter int VS_LEN   = 1,
   localparam int ADDR_W  = $clog2(COLS*ROWS),
   localparam int LINE_W  = $clog2(CHAR_H),
   localparam int GADDR_W = CODE_W + LINE_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gfx_mode,
   output logic [ADDR_W-1:0]   vram_addr,
   input  logic [CODE_W-1:0]   vram_rdata,
   output logic [GADDR_W-1:0]  glyph_addr,
   input  logic [CHAR_W-1:0]   glyph_data,
   output logic                dot_out,
   output logic                hsync,
   output logic                vsync
);

   logic              pix_last;
   logic [LINE_W-1:0] line_idx;
   logic [CODE_W-1:0] code_q;
   txtvid_flags_t     flags_s0, flags_s1;

   txtvid_timing #(
      .COLS(COLS), .ROWS(ROWS), .CHAR_W(CHAR_W), .CHAR_H(CHAR_H),
      .H_TOTAL(H_TOTAL), .HS_START(HS_START), .HS_LEN(HS_LEN),
      .V_ROWS(V_ROWS), .VS_START(VS_START), .VS_LEN(VS_LEN),
      .ADDR_W(ADDR_W), .LINE_W(LINE_W)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .pix_last(pix_last),
      .vram_addr(vram_addr), .line_idx(line_idx), .flags(flags_s0)
   );

   txtvid_fetch #(.CODE_W(CODE_W), .LINE_W(LINE_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .pix_last(pix_last),
      .vram_rdata(vram_rdata), .line_idx(line_idx), .flags_in(flags_s0),
      .code_q(code_q), .glyph_addr(glyph_addr), .flags_out(flags_s1)
   );

   txtvid_shifter #(.CHAR_W(CHAR_W), .CODE_W(CODE_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .pix_last(pix_last), .gfx_mode(gfx_mode),
      .glyph_data(glyph_data), .code_in(code_q), .flags_in(flags_s1),
      .dot_out(dot_out), .hsync(hsync), .vsync(vsync)
   );

   AST_GLYPH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_last |=> $stable(glyph_addr))                                     // R3
      else $error("glyph index changed inside a character group");

endmodule

// File: tb/txtvid_addr_gen_test.sv
module txtvid_addr_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int COLS = 4, ROWS = 3, CW = 8, CH = 2, CODE_W = 8;
   localparam int HT = 8, HS_S = 5, HS_L = 2;
   localparam int VR = 5, VS_S = 4, VS_L = 1;
   localparam int AW = $clog2(COLS*ROWS);
   localparam int LW = $clog2(CH);
   localparam int FRAME = HT*CW*CH*VR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gfx_mode = 1'b0;
   logic [AW-1:0]        vram_addr;
   logic [CODE_W-1:0]    vram_q;
   logic [CODE_W+LW-1:0] glyph_addr;
   logic [CW-1:0]        rom_q;
   logic dot_out, hsync, vsync;
   int   tcount;
   int   n_chk = 0;
   int   n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txtvid_addr_gen #(
      .COLS(COLS), .ROWS(ROWS), .CHAR_W(CW), .CHAR_H(CH), .CODE_W(CODE_W),
      .H_TOTAL(HT), .HS_START(HS_S), .HS_LEN(HS_L),
      .V_ROWS(VR), .VS_START(VS_S), .VS_LEN(VS_L)
   ) uut (
      .clk(clk), .rst_n(rst_n), .gfx_mode(gfx_mode),
      .vram_addr(vram_addr), .vram_rdata(vram_q),
      .glyph_addr(glyph_addr), .glyph_data(rom_q),
      .dot_out(dot_out), .hsync(hsync), .vsync(vsync)
   );

   function automatic int vram_fn(input int a);
      return (a*37 + 11) & 255;
   endfunction

   function automatic int rom_fn(input int code, input int ln);
      return (code*5 + ln*99 + 1) & 255;
   endfunction

   // synchronous-read memory models
   always_ff @(posedge clk) begin
      vram_q <= CODE_W'(vram_fn(int'(vram_addr)));
      rom_q  <= CW'(rom_fn(int'(glyph_addr[CODE_W+LW-1:LW]), int'(glyph_addr[LW-1:0])));
   end

   // cycles since reset release
   always_ff @(posedge clk) begin
      if (!rst_n) tcount <= 0;
      else        tcount <= tcount + 1;
   end

   function automatic int g_col(input int g);  return g % HT;            endfunction
   function automatic int g_line(input int g); return (g / HT) % CH;     endfunction
   function automatic int g_row(input int g);  return (g / (HT*CH)) % VR; endfunction
   function automatic bit g_vis(input int g);
      return (g_col(g) < COLS) && (g_row(g) < ROWS);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0d actual=%0h expected=%0h", req, tcount, act, exp);
      end
   endtask

   // one sampled cycle: predict all outputs from the cycle count
   task automatic sample(input bit gfx);
      int t = tcount;
      int g = t / CW;
      int p = t % CW;
      if (g_vis(g))
         check("R2", 32'(vram_addr), 32'(g_row(g)*COLS + g_col(g)));
      if (g >= 1 && g_vis(g-1)) begin
         int code = vram_fn(g_row(g-1)*COLS + g_col(g-1));
         check("R3", 32'(glyph_addr), 32'((code << LW) | g_line(g-1)));
      end
      if (g < 2) begin
         check("R5", 32'(dot_out), 0);
         check("R6", 32'(hsync), 0);
         check("R7", 32'(vsync), 0);
      end else begin
         int d = g - 2;
         int c = g_col(d);
         int r = g_row(d);
         if (g_vis(d)) begin
            int code = vram_fn(r*COLS + c);
            int row_bits = gfx ? code : rom_fn(code, g_line(d));
            if (gfx) check("R9", 32'(dot_out), 32'((row_bits >> (CW-1-p)) & 1));
            else     check("R4", 32'(dot_out), 32'((row_bits >> (CW-1-p)) & 1));
         end else begin
            check("R5", 32'(dot_out), 0);
         end
         check("R6", 32'(hsync), 32'((c >= HS_S) && (c < HS_S+HS_L)));
         check("R7", 32'(vsync), 32'((r >= VS_S) && (r < VS_S+VS_L)));
      end
      if (t > 0 && (t % FRAME) == 0)
         check("R8", 32'(vram_addr), 0);
   endtask

   task automatic apply_reset(input bit gfx);
      @(negedge clk);
      rst_n    = 1'b0;
      gfx_mode = gfx;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R1", 32'({dot_out, hsync, vsync}), 0);
         check("R1", 32'(vram_addr), 0);
      end
      rst_n = 1'b1;
   endtask

   task automatic run(input int ncyc, input bit gfx);
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         sample(gfx);
      end
   endtask

   task automatic test_reset;
      apply_reset(1'b0);
   endtask

   task automatic test_text_frame;        // R2 R3 R4 R5 over one field
      apply_reset(1'b0);
      run(FRAME + 2*CW, 1'b0);
   endtask

   task automatic test_sync_wrap;         // R6 R7 R8 across two field wraps
      apply_reset(1'b0);
      run(2*FRAME + 3*CW, 1'b0);
   endtask

   task automatic test_graphics;          // R9 bypass over a full field
      apply_reset(1'b1);
      run(FRAME + CW, 1'b1);
   endtask

   task automatic test_midrun_reset;      // R1 after activity, then clean restart
      apply_reset(1'b0);
      run(300, 1'b0);
      apply_reset(1'b0);
      run(HT*CW*CH + CW, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      n_bad++;
      $display("FAIL watchdog expired at t=%0d actual=running expected=finished", tcount);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      test_reset();
      test_text_frame();
      test_sync_wrap();
      test_graphics();
      test_midrun_reset();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule